// File: doc/BRIEF.md
# Three-Stage Pipelined Load/Store Core

A small load/store processor core built as a three-stage pipeline. Stage I reads the program word at the program counter. Stage A decodes the opcode and register fields together, which the fixed 16-bit format allows, and runs the ALU. The ALU produces a data result, an effective address or a branch target, depending on the instruction. Stage E routes that ALU value to exactly one place: the register file, the data-memory address port or the program counter. Program and data live in two separate internal arrays, so a fetch never competes with a load or store.

The core has no stall logic and no load forwarding. Software must respect two fixed delay rules. A loaded register is not visible to the instruction directly after the load. A branch executes the two words fetched behind it before control moves to the target. Slots that cannot be filled with useful work hold the all-zero no-op.

The memories are filled through a write port while the core is held in reset. After the run, a combinational peek port reads the architectural register and memory state.

Top module: `pipe3_core`

## Requirements
- R1: While rstN is low (synchronous, active low) pcOut is 0, every register reads 0 and no register or memory write is issued by the pipeline.
- R2: With no branch in stage E, pcOut rises by one every cycle, wrapping at the program depth.
- R3: Word layout: opcode in [15:12], destination rd in [11:9], source ra in [8:6], source rb in [5:3], signed immediate in [5:0], absolute branch target in [11:0]. Opcodes: 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 xor (rd = ra op rb), 6 add-immediate (rd = ra + imm).
- R4: A register written by an ALU instruction is read with its new value by the very next instruction (the stage-E write is seen by the stage-A read in the same cycle).
- R5: Opcode 7 loads rd from data memory. The instruction directly after a load that reads rd gets the value rd held before the load. The instruction two words after the load gets the loaded value.
- R6: Load and store (opcode 8, data taken from rd) address data memory at ra + sign-extended imm, modulo the data depth. A load directly after a store to the same address returns the stored value.
- R7: Opcode 9 is a delayed branch. The two words after it execute. The word three after it does not. pcOut equals the target in the cycle after the branch reaches stage E.
- R8: Opcodes 10 to 15 change no register, no memory word and no program flow.
- R9: ldWe writes ldData at ldAddr into data memory when ldToData is 1 and into program memory when it is 0. peekRegData and peekMemData show register peekReg and data word peekAddr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ldWe | input | 1 | Memory preload write strobe |
| ldToData | input | 1 | 1 selects data memory, 0 program memory |
| ldAddr | input | LD_W | Preload word address |
| ldData | input | 16 | Preload word |
| peekReg | input | 3 | Register to observe |
| peekRegData | output | 16 | Value of register peekReg |
| peekAddr | input | DADDR_W | Data word to observe |
| peekMemData | output | 16 | Data memory word at peekAddr |
| pcOut | output | IADDR_W | Current fetch address |

## Verification
The bench uses the default 64-word program memory and 32-word data memory. This is room for directed programs with and without the load no-op, plus random ALU programs of about forty words that end in a self-branch loop. The 32-word data depth lets a negative displacement from a small base wrap to the top word, which exercises the modulo addressing. Random programs mix in the undefined opcodes and are compared against a sequential model kept in the bench.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int XLEN    = 16;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int REG_CNT = 8;
  localparam int RSEL_W  = $clog2(REG_CNT);
  localparam int IMM_W   = 6;
  localparam int TGT_W   = 12;
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - RSEL_W;
  localparam int RA_LSB  = RD_LSB - RSEL_W;
  localparam int RB_LSB  = RA_LSB - RSEL_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
    OP_XOR = 4'd5, OP_ADDI = 4'd6, OP_LD = 4'd7, OP_ST = 4'd8, OP_BR = 4'd9
  } opcodeT;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASSB
  } aluOpT;

  typedef enum logic [2:0] {
    DST_NONE, DST_REG, DST_LOAD, DST_STORE, DST_PC
  } dstT;

  // Stage-A operation select plus stage-E destination strobes
  typedef struct packed {
    aluOpT             aluOp;
    logic              useImm;
    logic              useTgt;
    logic              regWe;
    logic              loadWe;
    logic              storeWe;
    logic              pcLoad;
    logic [RSEL_W-1:0] wrSel;
  } strobeT;
endpackage

// File: rtl/pipe3_ram.sv
module pipe3_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int N_RD  = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              wAddr,
  input  logic [WIDTH-1:0]           wData,
  input  logic [N_RD-1:0][AW-1:0]    rAddr,
  output logic [N_RD-1:0][WIDTH-1:0] rData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rData[g] = mem[rAddr[g]];
  end
endmodule

// File: rtl/pipe3_ctrl.sv
module pipe3_ctrl
  import pipe3_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrA,
  output strobeT             strb
);
  aluOpT             aluOpA;
  logic              useImmA;
  logic              useTgtA;
  dstT               dstA;
  dstT               dstE;
  logic [RSEL_W-1:0] wrSelE;

  // Stage A decode
  always_comb begin
    aluOpA  = ALU_ADD;
    useImmA = 1'b0;
    useTgtA = 1'b0;
    dstA    = DST_NONE;
    case (instrA[OPC_LSB +: OPC_W])
      OP_ADD:  dstA = DST_REG;
      OP_SUB:  begin aluOpA = ALU_SUB; dstA = DST_REG; end
      OP_AND:  begin aluOpA = ALU_AND; dstA = DST_REG; end
      OP_OR:   begin aluOpA = ALU_OR;  dstA = DST_REG; end
      OP_XOR:  begin aluOpA = ALU_XOR; dstA = DST_REG; end
      OP_ADDI: begin useImmA = 1'b1; dstA = DST_REG; end
      OP_LD:   begin useImmA = 1'b1; dstA = DST_LOAD; end
      OP_ST:   begin useImmA = 1'b1; dstA = DST_STORE; end
      OP_BR:   begin aluOpA = ALU_PASSB; useTgtA = 1'b1; dstA = DST_PC; end
      default: dstA = DST_NONE;
    endcase
  end

  // Stage E destination register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstE   <= DST_NONE;
      wrSelE <= '0;
    end else begin
      dstE   <= dstA;
      wrSelE <= instrA[RD_LSB +: RSEL_W];
    end
  end

  always_comb begin
    strb.aluOp   = aluOpA;
    strb.useImm  = useImmA;
    strb.useTgt  = useTgtA;
    strb.regWe   = (dstE == DST_REG);
    strb.loadWe  = (dstE == DST_LOAD);
    strb.storeWe = (dstE == DST_STORE);
    strb.pcLoad  = (dstE == DST_PC);
    strb.wrSel   = wrSelE;
  end
endmodule

// File: rtl/pipe3_dpath.sv
module pipe3_dpath
  import pipe3_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 32,
  localparam int IADDR_W   = $clog2(IMEM_DEPTH),
  localparam int DADDR_W   = $clog2(DMEM_DEPTH),
  localparam int LD_W      = (IADDR_W > DADDR_W) ? IADDR_W : DADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldWe,
  input  logic               ldToData,
  input  logic [LD_W-1:0]    ldAddr,
  input  logic [XLEN-1:0]    ldData,
  input  logic [RSEL_W-1:0]  peekReg,
  output logic [XLEN-1:0]    peekRegData,
  input  logic [DADDR_W-1:0] peekAddr,
  output logic [XLEN-1:0]    peekMemData,
  input  strobeT             strb,
  output logic [INSTR_W-1:0] instrA,
  output logic [IADDR_W-1:0] pcOut,
  output logic [XLEN-1:0]    eResult
);
  localparam int N_SRC = 3;

  logic [IADDR_W-1:0]            pc;
  logic [INSTR_W-1:0]            imemRd;
  logic [1:0][XLEN-1:0]          dmemRd;
  logic [XLEN-1:0]               rf [REG_CNT];
  logic [N_SRC-1:0][RSEL_W-1:0]  rdSel;
  logic [N_SRC-1:0][XLEN-1:0]    rdVal;
  logic [XLEN-1:0]               opB;
  logic [XLEN-1:0]               aluRes;
  logic [XLEN-1:0]               eStore;
  logic                          dWe;
  logic [DADDR_W-1:0]            dAddr;
  logic [XLEN-1:0]               dData;

  // Program memory, one read port at the fetch address
  pipe3_ram #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W), .N_RD(1)) u_imem (
    .clk   (clk),
    .we    (ldWe && !ldToData),
    .wAddr (ldAddr[IADDR_W-1:0]),
    .wData (ldData),
    .rAddr (pc),
    .rData (imemRd)
  );

  // Data memory: port 0 for stage E, port 1 for observation
  always_comb begin
    if (ldWe && ldToData) begin
      dWe   = 1'b1;
      dAddr = ldAddr[DADDR_W-1:0];
      dData = ldData;
    end else begin
      dWe   = strb.storeWe;
      dAddr = eResult[DADDR_W-1:0];
      dData = eStore;
    end
  end

  pipe3_ram #(.DEPTH(DMEM_DEPTH), .WIDTH(XLEN), .N_RD(2)) u_dmem (
    .clk   (clk),
    .we    (dWe),
    .wAddr (dAddr),
    .wData (dData),
    .rAddr ({peekAddr, eResult[DADDR_W-1:0]}),
    .rData (dmemRd)
  );
  assign peekMemData = dmemRd[1];

  // Stage I: fetch and program counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      instrA <= '0;
    end else begin
      pc     <= strb.pcLoad ? eResult[IADDR_W-1:0] : pc + 1'b1;
      instrA <= imemRd;
    end
  end
  assign pcOut = pc;

  // Stage A: register reads with same-cycle view of the stage-E ALU write
  assign rdSel[0] = instrA[RA_LSB +: RSEL_W];
  assign rdSel[1] = instrA[RB_LSB +: RSEL_W];
  assign rdSel[2] = instrA[RD_LSB +: RSEL_W];

  for (genvar p = 0; p < N_SRC; p++) begin : g_src
    assign rdVal[p] = (strb.regWe && strb.wrSel == rdSel[p]) ? eResult : rf[rdSel[p]];
  end

  always_comb begin
    if (strb.useTgt)
      opB = XLEN'(instrA[TGT_W-1:0]);
    else if (strb.useImm)
      opB = {{(XLEN-IMM_W){instrA[IMM_W-1]}}, instrA[IMM_W-1:0]};
    else
      opB = rdVal[1];
  end

  always_comb begin
    case (strb.aluOp)
      ALU_ADD:   aluRes = rdVal[0] + opB;
      ALU_SUB:   aluRes = rdVal[0] - opB;
      ALU_AND:   aluRes = rdVal[0] & opB;
      ALU_OR:    aluRes = rdVal[0] | opB;
      ALU_XOR:   aluRes = rdVal[0] ^ opB;
      default:   aluRes = opB;
    endcase
  end

  // Stage E registers and register-file write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eResult <= '0;
      eStore  <= '0;
    end else begin
      eResult <= aluRes;
      eStore  <= rdVal[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) rf[i] <= '0;
    end else if (strb.regWe) begin
      rf[strb.wrSel] <= eResult;
    end else if (strb.loadWe) begin
      rf[strb.wrSel] <= dmemRd[0];
    end
  end

  assign peekRegData = rf[peekReg];
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 32,
  localparam int IADDR_W   = $clog2(IMEM_DEPTH),
  localparam int DADDR_W   = $clog2(DMEM_DEPTH),
  localparam int LD_W      = (IADDR_W > DADDR_W) ? IADDR_W : DADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldWe,
  input  logic               ldToData,
  input  logic [LD_W-1:0]    ldAddr,
  input  logic [XLEN-1:0]    ldData,
  input  logic [RSEL_W-1:0]  peekReg,
  output logic [XLEN-1:0]    peekRegData,
  input  logic [DADDR_W-1:0] peekAddr,
  output logic [XLEN-1:0]    peekMemData,
  output logic [IADDR_W-1:0] pcOut
);
  strobeT             strb;
  logic [INSTR_W-1:0] instrA;
  logic [XLEN-1:0]    eResult;

  pipe3_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .instrA (instrA),
    .strb   (strb)
  );

  pipe3_dpath #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ldWe        (ldWe),
    .ldToData    (ldToData),
    .ldAddr      (ldAddr),
    .ldData      (ldData),
    .peekReg     (peekReg),
    .peekRegData (peekRegData),
    .peekAddr    (peekAddr),
    .peekMemData (peekMemData),
    .strb        (strb),
    .instrA      (instrA),
    .pcOut       (pcOut),
    .eResult     (eResult)
  );
endmodule

// File: rtl/pipe3_core_chk.sv
module pipe3_core_chk
  import pipe3_pkg::*;
#(
  parameter int IADDR_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [IADDR_W-1:0] pcOut,
  input strobeT             strb,
  input logic [INSTR_W-1:0] instrA,
  input logic [XLEN-1:0]    eResult
);
  p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> pcOut == '0);

  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pcLoad |=> pcOut == IADDR_W'($past(pcOut) + 1'b1));

  p_branch_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.pcLoad |=> pcOut == $past(eResult[IADDR_W-1:0]));

  p_branch_reaches_e_r7: assert property (@(posedge clk) disable iff (!rstN)
    instrA[OPC_LSB +: OPC_W] == OP_BR |=> strb.pcLoad);

  p_undefined_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    instrA[OPC_LSB +: OPC_W] >= 4'd10
      |=> !(strb.regWe || strb.loadWe || strb.storeWe || strb.pcLoad));
endmodule

bind pipe3_core pipe3_core_chk #(.IADDR_W(IADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pcOut   (pcOut),
  .strb    (strb),
  .instrA  (instrA),
  .eResult (eResult)
);

// File: tb/pipe3_core_tb.sv
`timescale 1ns/1ps
module pipe3_core_tb;
  import pipe3_pkg::*;

  localparam int IMEM_DEPTH = 64;
  localparam int DMEM_DEPTH = 32;
  localparam int IADDR_W    = $clog2(IMEM_DEPTH);
  localparam int DADDR_W    = $clog2(DMEM_DEPTH);
  localparam int LD_W       = (IADDR_W > DADDR_W) ? IADDR_W : DADDR_W;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               ldWe = 1'b0;
  logic               ldToData = 1'b0;
  logic [LD_W-1:0]    ldAddr = '0;
  logic [XLEN-1:0]    ldData = '0;
  logic [RSEL_W-1:0]  peekReg = '0;
  logic [XLEN-1:0]    peekRegData;
  logic [DADDR_W-1:0] peekAddr = '0;
  logic [XLEN-1:0]    peekMemData;
  logic [IADDR_W-1:0] pcOut;

  pipe3_core #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) u_dut (
    .clk, .rstN, .ldWe, .ldToData, .ldAddr, .ldData,
    .peekReg, .peekRegData, .peekAddr, .peekMemData, .pcOut
  );

  always #2.5 clk = ~clk;

  int nTests = 0;
  int nFails = 0;
  logic [XLEN-1:0] prog [IMEM_DEPTH];
  logic [XLEN-1:0] dInit [DMEM_DEPTH];
  int progLen;

  function automatic logic [15:0] encR(input logic [3:0] op, input int rd, input int ra, input int rb);
    return {op, 3'(rd), 3'(ra), 3'(rb), 3'b000};
  endfunction

  function automatic logic [15:0] encI(input logic [3:0] op, input int rd, input int ra, input logic [5:0] imm);
    return {op, 3'(rd), 3'(ra), imm};
  endfunction

  function automatic logic [15:0] encB(input int tgt);
    return {4'd9, 12'(tgt)};
  endfunction

  function automatic logic [15:0] aluModel(input logic [3:0] op, input logic [15:0] a,
                                           input logic [15:0] b, input logic [5:0] imm);
    case (op)
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      default: return a + {{10{imm[5]}}, imm};
    endcase
  endfunction

  task automatic emit(input logic [15:0] w);
    prog[progLen] = w;
    progLen++;
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [15:0] v);
    peekReg = 3'(idx);
    #1;
    v = peekRegData;
  endtask

  task automatic readMem(input int addr, output logic [15:0] v);
    peekAddr = 5'(addr);
    #1;
    v = peekMemData;
  endtask

  // Hold reset, preload both memories, check reset state, then run
  task automatic loadRun(input int cycles);
    logic [15:0] v;
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < progLen; i++) begin
      ldWe = 1'b1; ldToData = 1'b0; ldAddr = LD_W'(i); ldData = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < DMEM_DEPTH; i++) begin
      ldWe = 1'b1; ldToData = 1'b1; ldAddr = LD_W'(i); ldData = dInit[i];
      @(negedge clk);
    end
    ldWe = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", 16'(pcOut), 16'd0);
    for (int r = 0; r < REG_CNT; r++) begin
      readReg(r, v);
      check("R1", $sformatf("reg %0d in reset", r), v, 16'd0);
    end
    @(negedge clk);
    rstN = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  // Directed program: load delay, store/load, wrap, undefined op, branch slots
  task automatic runDirected(input bit pad);
    logic [15:0] v;
    int loopAt;
    int brAt;
    progLen = 0;
    for (int i = 0; i < DMEM_DEPTH; i++) dInit[i] = '0;
    dInit[3] = 16'h1234;
    emit(encI(4'd6, 1, 0, 6'd3));        // r1 = 3
    emit(encI(4'd7, 2, 1, 6'd0));        // r2 = mem[3]
    if (pad) emit(16'h0000);
    emit(encR(4'd1, 3, 2, 0));           // r3 = r2 (old without pad)
    emit(encR(4'd1, 4, 2, 0));           // r4 = r2 (loaded)
    emit(encI(4'd6, 5, 1, 6'd1));        // r5 = 4
    emit(encI(4'd8, 4, 5, 6'd0));        // mem[4] = r4
    emit(encI(4'd8, 4, 1, 6'h3C));       // mem[(3-4) mod 32] = r4
    emit(encI(4'd7, 6, 5, 6'd0));        // r6 = mem[4]
    emit(encR(4'hF, 5, 1, 1));           // undefined opcode
    brAt = progLen;
    emit(encB(brAt + 4));
    emit(encI(4'd6, 7, 0, 6'd9));        // slot 1: r7 = 9
    emit(encR(4'd2, 0, 7, 1));           // slot 2: r0 = r7 - r1
    emit(encI(4'd6, 7, 0, 6'd31));       // skipped
    loopAt = progLen;
    emit(encB(loopAt));
    emit(16'h0000);
    emit(16'h0000);
    loadRun(120);

    readReg(3, v); check("R5", pad ? "padded load use" : "load-delay old value", v, pad ? 16'h1234 : 16'h0000);
    readReg(2, v); check("R5", "loaded register", v, 16'h1234);
    readReg(4, v); check("R5", "second word after load", v, 16'h1234);
    readReg(1, v); check("R4", "r1 from addi", v, 16'd3);
    readReg(5, v); check("R8", "undefined op leaves r5", v, 16'd4);
    readReg(6, v); check("R6", "load after store", v, 16'h1234);
    readMem(4, v); check("R6", "store to mem[4]", v, 16'h1234);
    readMem(31, v); check("R6", "wrapped store mem[31]", v, 16'h1234);
    readMem(3, v); check("R9", "preloaded mem[3]", v, 16'h1234);
    readReg(7, v); check("R7", "slot executed, skipped word not", v, 16'd9);
    readReg(0, v); check("R4", "slot subtract uses fresh r7", v, 16'd6);
    check("R7", "pc held in branch loop",
          16'((int'(pcOut) >= loopAt) && (int'(pcOut) <= loopAt + 2)), 16'd1);
  endtask

  // Random ALU programs compared with a sequential model
  task automatic runRandom(input int round);
    logic [15:0] model [REG_CNT];
    logic [15:0] v;
    int loopAt;
    progLen = 0;
    for (int i = 0; i < DMEM_DEPTH; i++) dInit[i] = '0;
    for (int r = 0; r < REG_CNT; r++) model[r] = '0;
    for (int r = 1; r < REG_CNT; r++) begin
      logic [5:0] imm = 6'($urandom);
      emit(encI(4'd6, r, 0, imm));
      model[r] = {{10{imm[5]}}, imm};
    end
    for (int k = 0; k < 30; k++) begin
      int pick = $urandom_range(0, 8);
      int rd = $urandom_range(0, 7);
      int ra = $urandom_range(0, 7);
      int rb = $urandom_range(0, 7);
      logic [5:0] imm = 6'($urandom);
      logic [3:0] op;
      if (pick <= 5) op = 4'(pick + 1);
      else op = 4'($urandom_range(10, 15));
      if (op == 4'd6) begin
        emit(encI(op, rd, ra, imm));
        model[rd] = aluModel(op, model[ra], 16'd0, imm);
      end else begin
        emit(encR(op, rd, ra, rb));
        if (op <= 4'd5) model[rd] = aluModel(op, model[ra], model[rb], 6'd0);
      end
    end
    loopAt = progLen;
    emit(encB(loopAt));
    emit(16'h0000);
    emit(16'h0000);
    loadRun(100);
    for (int r = 0; r < REG_CNT; r++) begin
      readReg(r, v);
      check("R3", $sformatf("random round %0d reg %0d", round, r), v, model[r]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    runDirected(1'b0);
    runDirected(1'b1);
    for (int rnd = 0; rnd < 6; rnd++) runRandom(rnd);
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nTests++;
    nFails++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule